// File: doc/BRIEF.md
# Doze Clock Ratio Controller

This block keeps a 16-bit clock divisor control word and turns it into a clock-enable for a processor that runs more slowly than the peripheral clock it shares. A bus-side write port loads the word. A read port returns the stored word, and the one unimplemented bit always reads as zero. A 3-bit slow-select field picks a processor-to-peripheral ratio between 1:1 and 1:128 in powers of two. A slow-enable bit switches the reduction on. When slow-enable is clear, the processor runs at full rate.

A recover-on-interrupt bit lets hardware restore full speed. When this bit is set, any interrupt event clears slow-enable, so the processor is back at 1:1 as soon as the interrupt arrives. The oscillator postscaler and PLL divider fields are only stored and read back. No oscillator, PLL or postscaler circuitry is included.

The processor clock-enable is registered. It pulses once every N peripheral cycles, where N is the effective ratio. Its phase restarts whenever the effective ratio changes.

Top module: `doze_ratio_ctl`

## Requirements
- R1: After a synchronous reset the read port returns 16'h3040, and `cpu_clk_en` is high. In that word bits 14..12 hold 3'b011, bits 7..6 hold 2'b01 and every other bit is 0.
- R2: A write stores `wr_data` in the cycle after `wr_en`, except for bit 5, which always reads 0. The field positions are: bit 15 recover-on-interrupt, bits 14..12 slow-select, bit 11 slow-enable, bits 10..8 oscillator postscaler, bits 7..6 PLL output divider, bits 4..0 PLL input divider.
- R3: While slow-enable (bit 11) is 0, `cpu_clk_en` is high in every cycle, whatever the slow-select field holds.
- R4: While slow-enable is 1 and slow-select holds code S, `cpu_clk_en` is high exactly once every 2^S cycles. Code 000 gives 1:1 and code 111 gives 1:128.
- R5: The cycle after the effective ratio changes, `cpu_clk_en` is high and the phase count starts again from zero. The effective ratio is 1 when slow-enable is 0 and 2^S otherwise. The enable lags the register update by one cycle.
- R6: If the stored recover-on-interrupt bit is 1 when `irq_evt` is high, slow-enable reads 0 in the next cycle and all other bits keep their values.
- R7: If the stored recover-on-interrupt bit is 0, `irq_evt` changes nothing in the register.
- R8: If a write that sets slow-enable coincides with an interrupt clear, the clear wins. The other written fields are still stored.
- R9: The interrupt clear is governed by the recover-on-interrupt bit stored before the clock edge. A write that sets that bit in the same cycle as an interrupt does not trigger a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to store |
| irq_evt | input | 1 | Any interrupt event, one cycle per event |
| cpu_clk_en | output | 1 | Registered processor clock-enable |
| cfg_rd_data | output | 16 | Stored control word |

## Verification
The bench targets a write that sets slow-enable while an interrupt arrives with recovery armed. A design with the priorities reversed would leave the processor slowed. It also covers a write that arms recovery in the same cycle as an interrupt: a design that looked at the incoming bit rather than the stored one would clear slow-enable too early. Ratio changes in the middle of a period are checked for a phase restart, because a design that kept the old count would produce a late or missing pulse. The 1:1 case and slow-enable being off are checked for a continuously high enable, because a design with an off-by-one in its divider would drop cycles there.

// File: rtl/doze_pkg.sv
package doze_pkg;

  typedef struct packed {
    logic       rec_on_irq;
    logic [2:0] slow_sel;
    logic       slow_en;
    logic [2:0] osc_post;
    logic [1:0] pll_out_div;
    logic       rsvd0;
    logic [4:0] pll_in_div;
  } doze_cfg_t;

  localparam int CFG_W = $bits(doze_cfg_t);
  localparam int SEL_W = 3;

  localparam logic [CFG_W-1:0] CFG_RST     = 16'h3040;
  localparam logic [CFG_W-1:0] CFG_WR_MASK = 16'hFFDF;

endpackage

// File: rtl/doze_cfg_reg.sv
module doze_cfg_reg
  import doze_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             irq_evt,
  output doze_cfg_t        cfg_q
);

  doze_cfg_t cfg_d;
  logic      hw_clear;

  // The recovery decision uses the bit already stored, not the incoming one.
  assign hw_clear = irq_evt && cfg_q.rec_on_irq;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = doze_cfg_t'(wr_data & CFG_WR_MASK);
    end
    if (hw_clear) begin
      cfg_d.slow_en = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= doze_cfg_t'(CFG_RST);
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // R6: an armed interrupt drops slow-enable in the next cycle
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && cfg_q.rec_on_irq) |=> !cfg_q.slow_en);

  // R7: an unarmed interrupt with no write leaves the word as it is
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && !cfg_q.rec_on_irq && !wr_en) |=> $stable(cfg_q));

  // R2: a plain write lands in the next cycle with bit 5 cleared
  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !irq_evt) |=> (cfg_q == ($past(wr_data) & CFG_WR_MASK)));

  // R8: a write with a clear armed keeps every field but slow-enable
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && irq_evt && cfg_q.rec_on_irq) |=>
      (!cfg_q.slow_en && cfg_q.slow_sel == $past(wr_data[14:12])));

endmodule

// File: rtl/doze_ratio_sel.sv
module doze_ratio_sel
  import doze_pkg::*;
#(
  parameter int SEL_BITS = SEL_W
) (
  input  doze_cfg_t            cfg,
  output logic [SEL_BITS-1:0]  eff_sel
);

  // A zero code stands for 1:1; reduction applies only with slow-enable set.
  assign eff_sel = cfg.slow_en ? SEL_BITS'(cfg.slow_sel) : '0;

endmodule

// File: rtl/doze_phase_gen.sv
module doze_phase_gen #(
  parameter int SEL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_BITS-1:0] eff_sel,
  output logic                clk_en
);

  localparam int CNT_W = (1 << SEL_BITS) - 1;

  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_cur;
  logic [CNT_W-1:0]    last_phase;
  logic [SEL_BITS-1:0] prev_sel_q;
  logic                restart;

  assign restart    = (eff_sel != prev_sel_q);
  assign last_phase = CNT_W'((64'd1 << eff_sel) - 64'd1);
  assign cnt_cur    = restart ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      prev_sel_q <= '0;
      clk_en     <= 1'b1;
    end else begin
      prev_sel_q <= eff_sel;
      clk_en     <= (cnt_cur == '0);
      cnt_q      <= (cnt_cur == last_phase) ? '0 : cnt_cur + 1'b1;
    end
  end

  // R3: at the 1:1 ratio the enable stays high
  p_full_speed_r3: assert property (@(posedge clk) disable iff (rst)
    (eff_sel == '0) |=> clk_en);

  // R5: a ratio change restarts the phase with a pulse
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> clk_en);

  // R4: with a steady ratio above 1:1, a pulse is followed by a gap
  p_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (clk_en && eff_sel != '0 && !restart) |=> !clk_en);

endmodule

// File: rtl/doze_ratio_ctl.sv
module doze_ratio_ctl
  import doze_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        irq_evt,
  output logic        cpu_clk_en,
  output logic [15:0] cfg_rd_data
);

  doze_cfg_t          cfg_q;
  logic [SEL_W-1:0]   eff_sel;

  doze_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .irq_evt (irq_evt),
    .cfg_q   (cfg_q)
  );

  doze_ratio_sel #(.SEL_BITS(SEL_W)) u_sel (
    .cfg     (cfg_q),
    .eff_sel (eff_sel)
  );

  doze_phase_gen #(.SEL_BITS(SEL_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .eff_sel (eff_sel),
    .clk_en  (cpu_clk_en)
  );

  assign cfg_rd_data = cfg_q;

  // R2: the unimplemented bit never reads as one
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> !cfg_rd_data[5]);

endmodule

// File: tb/doze_ratio_ctl_tb.sv
module doze_ratio_ctl_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq_evt = 1'b0;
  logic        cpu_clk_en;
  logic [15:0] cfg_rd_data;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;
  int    cycles   = 0;

  // Reference state computed from the requirements
  logic [15:0] m_reg = 16'h3040;
  int          m_last_eff = 0;
  int          m_age = 0;
  logic        m_exp_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  doze_ratio_ctl dut_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .irq_evt     (irq_evt),
    .cpu_clk_en  (cpu_clk_en),
    .cfg_rd_data (cfg_rd_data)
  );

  function automatic int eff_of(logic [15:0] r);
    return r[11] ? int'(r[14:12]) : 0;
  endfunction

  function automatic logic [15:0] next_reg(logic [15:0] r, logic we,
                                           logic [15:0] d, logic irq);
    logic [15:0] n;
    n = we ? (d & 16'hFFDF) : r;
    if (irq && r[15]) n[11] = 1'b0;
    return n;
  endfunction

  always @(posedge clk) begin
    int e;
    cycles = cycles + 1;
    if (rst) begin
      m_reg = 16'h3040; m_last_eff = 0; m_age = 0; m_exp_en = 1'b1;
    end else begin
      e = eff_of(m_reg);
      if (e != m_last_eff) m_age = 0;
      else m_age = m_age + 1;
      m_exp_en   = ((m_age % (1 << e)) == 0);
      m_last_eff = e;
      m_reg      = next_reg(m_reg, wr_en, wr_data, irq_evt);
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Continuous comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " reg"}, cfg_rd_data, m_reg);
      chk({cur_req, " en"}, {15'd0, cpu_clk_en}, {15'd0, m_exp_en});
    end
  end

  task automatic drive(logic we, logic [15:0] d, logic irq);
    @(negedge clk);
    #1;
    wr_en = we; wr_data = d; irq_evt = irq;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 16'h0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > WDOG_LIMIT && !done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      finish_run();
    end
  end

  initial begin
    int pulses;
    int seed;
    logic [15:0] rnd;
    seed = 7;
    rnd = 16'($urandom(seed));
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset word", cfg_rd_data, 16'h3040);
    chk("R1 reset en", {15'd0, cpu_clk_en}, 16'd1);

    // R2: write with bit 5 set reads back cleared; slow 1:4 enabled
    cur_req = "R2";
    drive(1'b1, 16'h2DF5, 1'b0);
    drive(1'b0, 16'h0, 1'b0);
    chk("R2 stored word", cfg_rd_data, 16'h2DD5);
    // R5: pulse in the cycle after the register change
    cur_req = "R5";
    drive(1'b0, 16'h0, 1'b0);
    chk("R5 restart pulse", {15'd0, cpu_clk_en}, 16'd1);

    // R4: count pulses at 1:4 over 64 cycles
    cur_req = "R4";
    pulses = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (cpu_clk_en) pulses++;
    end
    chk("R4 pulses at 1:4", 16'(pulses), 16'd16);

    // R4: 1:128 ratio over 256 cycles
    drive(1'b1, 16'h7800, 1'b0);
    idle(1);
    pulses = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (cpu_clk_en) pulses++;
    end
    chk("R4 pulses at 1:128", 16'(pulses), 16'd2);

    // R3: slow-enable off, slow-select 111 -> full speed
    cur_req = "R3";
    drive(1'b1, 16'h7000, 1'b0);
    idle(2);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cpu_clk_en) pulses++;
    end
    chk("R3 enable held high", 16'(pulses), 16'd20);

    // R5: change ratio mid-period (1:8 then 1:2)
    cur_req = "R5";
    drive(1'b1, 16'h3800, 1'b0);
    idle(5);
    drive(1'b1, 16'h1800, 1'b0);
    idle(6);

    // R6: armed interrupt clears slow-enable
    cur_req = "R6";
    drive(1'b1, 16'hF8C3, 1'b0);
    idle(3);
    drive(1'b0, 16'h0, 1'b1);
    drive(1'b0, 16'h0, 1'b0);
    chk("R6 cleared word", cfg_rd_data, 16'hF0C3);
    idle(3);

    // R7: unarmed interrupt changes nothing
    cur_req = "R7";
    drive(1'b1, 16'h5A41, 1'b0);
    idle(2);
    drive(1'b0, 16'h0, 1'b1);
    drive(1'b0, 16'h0, 1'b0);
    chk("R7 word kept", cfg_rd_data, 16'h5A41);

    // R8: armed, write sets slow-enable with an interrupt: clear wins
    cur_req = "R8";
    drive(1'b1, 16'h8000, 1'b0);
    drive(1'b1, 16'hAB07, 1'b1);
    drive(1'b0, 16'h0, 1'b0);
    chk("R8 clear wins", cfg_rd_data, 16'hA307);
    idle(3);

    // R9: unarmed, write arms recovery with interrupt: no clear
    cur_req = "R9";
    drive(1'b1, 16'h0000, 1'b0);
    drive(1'b1, 16'hC800, 1'b1);
    drive(1'b0, 16'h0, 1'b0);
    chk("R9 stored bit governs", cfg_rd_data, 16'hC800);
    idle(4);

    // R4: random traffic against the reference
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic we, irq;
      we  = (($urandom() % 8) == 0);
      irq = (($urandom() % 10) == 0);
      rnd = 16'($urandom());
      drive(we, rnd, irq);
    end
    idle(4);
    finish_run();
  end

endmodule